// File: doc/BRIEF.md
# Storage Controller Command Register Interface

This block is the host-facing register file and command decoder of a parallel storage-bus controller. A processor reaches it with single-byte reads and writes. Address bits [5:2] select one of sixteen registers. The registers hold the following:

- a 16-bit transfer count, with the effective length driven out to a separate transfer engine;
- a small byte FIFO;
- a command register;
- status, interrupt-cause and sequence-step registers that software reads back after each command.

A command byte is decoded into register updates and an interrupt line. Bit 7 of the byte selects DMA mode and bits [6:0] give the opcode. Housekeeping commands complete in the cycle they are written. Commands that move data raise `xfer_req` and hold it until the transfer engine returns `xfer_done`. The completion codes are then loaded and the interrupt is raised.

Software acknowledges an interrupt by reading the interrupt-cause register. That read drops the line and clears every status bit except terminal count. The interrupt of a bus-reset command can be masked with one configuration bit. Bus-phase signalling, the attached devices and the DMA engine itself are outside this block.

Top module: `stor_cmd_regif`

## Requirements

- R1: After `rst`, these are the values at each register index:
  - every index reads 0x00, except index 14, which reads the identification value 0x04;
  - `irq`, `xfer_req` and `dma_mode` are 0 and `xfer_len` is 65536.
  - Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R2: Index 0 is the low byte and index 1 the high byte of the transfer count, and both read back. `xfer_len` equals the count, except that a count of 0 gives 65536.
- R3: A write to index 3 stores the command byte, which reads back at index 3. Bit 7 drives `dma_mode`. Opcode 0x00 and any undefined opcode change nothing else.
- R4: Opcode 0x01 (flush) sets interrupt cause (index 5) to 0x08 and sequence (index 6) to 0x00. It empties the FIFO and leaves `irq` unchanged.
- R5: Opcode 0x02 returns every register, the FIFO, `irq` and `xfer_req` to the R1 state. This also applies while a transfer is pending.
- R6: Opcode 0x03 (bus reset) sets interrupt cause to 0x80. It raises `irq` only when bit 6 of configuration register index 8 is 0.
- R7: Opcodes 0x42 and 0x43 (select) with a target ID below 4 raise `xfer_req` in the next cycle. Target ID is bits [2:0] of the index 4 write. `xfer_req` holds until `xfer_done`. On the following cycle `xfer_req` is low and `irq` is high, with status (index 4) 0x91, cause 0x18 and sequence 0x04.
- R8: A select with a target ID of 4 or more raises no request. In the next cycle it sets status 0x80, cause 0x20 (disconnect), sequence 0x00 and `irq`.
- R9: Opcode 0x10 (transfer) raises `xfer_req`. On `xfer_done` it sets status 0x93, cause 0x10, sequence 0x00 and `irq`.
- R10: A read of index 5 returns the cause byte. Afterwards status keeps only bit 4 (terminal count, 0x10) and `irq` falls.
- R11: A write to index 11 keeps only the bits of mask 0x15. Indices 8 and 12 to 15 keep the full byte. Writes to indices 4 to 7, 9 and 10 leave what those indices read unchanged, and indices 9 and 10 read 0x00.
- R12: The byte FIFO behaves as follows:
  - writes to index 2 push into it, up to 16 bytes, and writes to a full FIFO are dropped;
  - index 7 reads the byte count;
  - reads of index 2 pop bytes in order;
  - a read of an empty FIFO returns the last popped byte, or 0x00 after a flush or reset.
- R13: While `xfer_req` is high, command writes other than opcode 0x02 are ignored, including the command register itself. `xfer_done` while `xfer_req` is low has no effect.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address; bits [5:2] select the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt line |
| xfer_req | output | 1 | Transfer request to the data engine |
| xfer_done | input | 1 | Transfer completion from the data engine |
| dma_mode | output | 1 | DMA mode bit of the last accepted command |
| xfer_len | output | 17 | Effective transfer length in bytes |

## Verification

The assertions assume that read and write strobes never coincide. They also assume that `xfer_done` does not arrive in the same cycle as an interrupt-cause read. The completion-versus-clear priority is therefore not relied on. The bench drives exactly one bus operation per task, separated by an idle cycle, and pulses `xfer_done` on its own. It also issues `xfer_done` while no request is pending, to show that it is ignored.

// File: rtl/stor_regif_pkg.sv
package stor_regif_pkg;

  // Register indices (address bits [5:2])
  localparam logic [3:0] IX_CNTLO  = 4'd0;
  localparam logic [3:0] IX_CNTHI  = 4'd1;
  localparam logic [3:0] IX_FIFO   = 4'd2;
  localparam logic [3:0] IX_CMD    = 4'd3;
  localparam logic [3:0] IX_STAT   = 4'd4;
  localparam logic [3:0] IX_INTR   = 4'd5;
  localparam logic [3:0] IX_SEQ    = 4'd6;
  localparam logic [3:0] IX_FCNT   = 4'd7;
  localparam logic [3:0] IX_CFG    = 4'd8;
  localparam logic [3:0] IX_R11    = 4'd11;
  localparam int         IX_HIBASE = 12;
  localparam int         IX_ID     = 14;

  // Status bits
  localparam logic [7:0] ST_IRQ = 8'h80;
  localparam logic [7:0] ST_TC  = 8'h10;
  localparam logic [7:0] PH_DIN = 8'h01;
  localparam logic [7:0] PH_ST  = 8'h03;

  // Interrupt-cause bits
  localparam logic [7:0] IS_FC  = 8'h08;
  localparam logic [7:0] IS_BS  = 8'h10;
  localparam logic [7:0] IS_DC  = 8'h20;
  localparam logic [7:0] IS_RST = 8'h80;

  // Sequence steps
  localparam logic [7:0] SQ_IDLE  = 8'h00;
  localparam logic [7:0] SQ_CDONE = 8'h04;

  localparam logic [7:0] ID_VALUE  = 8'h04;
  localparam logic [7:0] R11_MASK  = 8'h15;
  localparam int         CFG_MASKB = 6;

  typedef enum logic [6:0] {
    OP_NOP     = 7'h00,
    OP_FLUSH   = 7'h01,
    OP_CHIPRST = 7'h02,
    OP_BUSRST  = 7'h03,
    OP_XFER    = 7'h10,
    OP_SEL     = 7'h42,
    OP_SELSTOP = 7'h43
  } opcode_e;

  typedef enum logic {JOB_XFER = 1'b0, JOB_SEL = 1'b1} job_e;

  typedef struct packed {
    logic       accept;
    logic       chiprst;
    logic       flush;
    logic       ld_stat;
    logic       ld_intr;
    logic       ld_seq;
    logic [7:0] status;
    logic [7:0] intr;
    logic [7:0] seq;
    logic       irq_set;
    logic       start;
    job_e       job;
  } act_t;

  // Result codes loaded when a pending transfer completes
  function automatic act_t done_codes(input job_e j);
    act_t a;
    a = '0;
    a.ld_stat = 1'b1;
    a.ld_intr = 1'b1;
    a.ld_seq  = 1'b1;
    a.irq_set = 1'b1;
    if (j == JOB_SEL) begin
      a.status = ST_IRQ | ST_TC | PH_DIN;
      a.intr   = IS_BS | IS_FC;
      a.seq    = SQ_CDONE;
    end else begin
      a.status = ST_IRQ | ST_TC | PH_ST;
      a.intr   = IS_BS;
      a.seq    = SQ_IDLE;
    end
    return a;
  endfunction

endpackage

// File: rtl/stor_byte_fifo.sv
module stor_byte_fifo #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] last;
  logic          full, empty, do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      last <= '0;
    end else begin
      if (do_push) begin
        wptr <= wrap_inc(wptr);
        cnt  <= cnt + 1'b1;
      end
      if (do_pop) begin
        last <= mem[rptr];
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          rptr <= '0;
          wptr <= '0;
        end else begin
          rptr <= wrap_inc(rptr);
        end
      end
    end
  end

  assign rdata = empty ? last : mem[rptr];
  assign count = cnt;

endmodule

// File: rtl/stor_cmd_decode.sv
module stor_cmd_decode
  import stor_regif_pkg::*;
#(
  parameter int TGT_W     = 3,
  parameter int TGT_LIMIT = 4
) (
  input  logic [6:0]       opcode,
  input  logic [TGT_W-1:0] target,
  input  logic             busrst_mask,
  input  logic             busy,
  output act_t             act
);

  logic bad_target;
  assign bad_target = ({1'b0, target} >= (TGT_W + 1)'(TGT_LIMIT));

  always_comb begin
    act = '0;
    if (opcode == OP_CHIPRST) begin
      act.accept  = 1'b1;
      act.chiprst = 1'b1;
    end else if (!busy) begin
      act.accept = 1'b1;
      case (opcode)
        OP_FLUSH: begin
          act.flush   = 1'b1;
          act.ld_intr = 1'b1;
          act.intr    = IS_FC;
          act.ld_seq  = 1'b1;
          act.seq     = SQ_IDLE;
        end
        OP_BUSRST: begin
          act.ld_intr = 1'b1;
          act.intr    = IS_RST;
          act.irq_set = !busrst_mask;
        end
        OP_XFER: begin
          act.start = 1'b1;
          act.job   = JOB_XFER;
        end
        OP_SEL, OP_SELSTOP: begin
          if (bad_target) begin
            act.ld_stat = 1'b1;
            act.status  = ST_IRQ;
            act.ld_intr = 1'b1;
            act.intr    = IS_DC;
            act.ld_seq  = 1'b1;
            act.seq     = SQ_IDLE;
            act.irq_set = 1'b1;
          end else begin
            act.start = 1'b1;
            act.job   = JOB_SEL;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stor_cmd_regif.sv
module stor_cmd_regif
  import stor_regif_pkg::*;
#(
  parameter  int ADDR_W     = 6,
  parameter  int FIFO_DEPTH = 16,
  parameter  int TGT_W      = 3,
  parameter  int TGT_LIMIT  = 4,
  localparam int IDX_LSB    = 2,
  localparam int CNT_W      = 16,
  localparam int FCW        = $clog2(FIFO_DEPTH + 1),
  localparam int NHI        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq,
  output logic             xfer_req,
  input  logic             xfer_done,
  output logic             dma_mode,
  output logic [CNT_W:0]   xfer_len
);

  logic [3:0]       idx;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       cmd_q, status_q, intr_q, seq_q, cfg_q, r11_q;
  logic [7:0]       hi_q [NHI];
  logic [TGT_W-1:0] tgt_q;
  logic             irq_q, req_q;
  job_e             job_q;
  logic [7:0]       rdata_q, rsel;
  logic [7:0]       fifo_rdata;
  logic [FCW-1:0]   fifo_cnt;
  act_t             act, fin;
  logic             cmd_wr, soft_rst;

  assign idx      = bus_addr[ADDR_W-1:IDX_LSB];
  assign cmd_wr   = bus_wr && (idx == IX_CMD);
  assign soft_rst = cmd_wr && act.chiprst;
  assign fin      = done_codes(job_q);

  stor_cmd_decode #(.TGT_W(TGT_W), .TGT_LIMIT(TGT_LIMIT)) u_dec (
    .opcode      (bus_wdata[6:0]),
    .target      (tgt_q),
    .busrst_mask (cfg_q[CFG_MASKB]),
    .busy        (req_q),
    .act         (act)
  );

  stor_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (cmd_wr && (act.flush || act.chiprst)),
    .push  (bus_wr && (idx == IX_FIFO)),
    .wdata (bus_wdata),
    .pop   (bus_rd && (idx == IX_FIFO)),
    .rdata (fifo_rdata),
    .count (fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cnt_q    <= '0;
      cmd_q    <= '0;
      status_q <= '0;
      intr_q   <= '0;
      seq_q    <= '0;
      cfg_q    <= '0;
      r11_q    <= '0;
      tgt_q    <= '0;
      irq_q    <= 1'b0;
      req_q    <= 1'b0;
      job_q    <= JOB_XFER;
      for (int i = 0; i < NHI; i++)
        hi_q[i] <= (i == IX_ID - IX_HIBASE) ? ID_VALUE : 8'h00;
    end else begin
      // acknowledge by reading the cause register
      if (bus_rd && (idx == IX_INTR)) begin
        status_q <= status_q & ST_TC;
        irq_q    <= 1'b0;
      end
      // completion of a pending transfer
      if (req_q && xfer_done) begin
        status_q <= fin.status;
        intr_q   <= fin.intr;
        seq_q    <= fin.seq;
        irq_q    <= 1'b1;
        req_q    <= 1'b0;
      end
      if (bus_wr) begin
        case (idx)
          IX_CNTLO: cnt_q[7:0]  <= bus_wdata;
          IX_CNTHI: cnt_q[15:8] <= bus_wdata;
          IX_CMD: begin
            if (act.accept) begin
              cmd_q <= bus_wdata;
              if (act.ld_stat) status_q <= act.status;
              if (act.ld_intr) intr_q   <= act.intr;
              if (act.ld_seq)  seq_q    <= act.seq;
              if (act.irq_set) irq_q    <= 1'b1;
              if (act.start) begin
                req_q <= 1'b1;
                job_q <= act.job;
              end
            end
          end
          IX_STAT: tgt_q <= bus_wdata[TGT_W-1:0];
          IX_CFG:  cfg_q <= bus_wdata;
          IX_R11:  r11_q <= bus_wdata & R11_MASK;
          4'd12, 4'd13, 4'd14, 4'd15: hi_q[idx[1:0]] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      IX_CNTLO: rsel = cnt_q[7:0];
      IX_CNTHI: rsel = cnt_q[15:8];
      IX_FIFO:  rsel = fifo_rdata;
      IX_CMD:   rsel = cmd_q;
      IX_STAT:  rsel = status_q;
      IX_INTR:  rsel = intr_q;
      IX_SEQ:   rsel = seq_q;
      IX_FCNT:  rsel = 8'(fifo_cnt);
      IX_CFG:   rsel = cfg_q;
      IX_R11:   rsel = r11_q;
      4'd12, 4'd13, 4'd14, 4'd15: rsel = hi_q[idx[1:0]];
      default:  rsel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rsel;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
  assign xfer_req  = req_q;
  assign dma_mode  = cmd_q[7];
  assign xfer_len  = (cnt_q == '0) ? (CNT_W + 1)'(1 << CNT_W) : {1'b0, cnt_q};

endmodule

// File: rtl/stor_cmd_regif_chk.sv
module stor_cmd_regif_chk
  import stor_regif_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  parameter  int TGT_W      = 3,
  parameter  int TGT_LIMIT  = 4,
  localparam int FCW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       idx,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [6:0]       opcode,
  input logic             irq,
  input logic             xfer_req,
  input logic             xfer_done,
  input logic [FCW-1:0]   fifo_cnt,
  input logic             cfg_mask,
  input logic [TGT_W-1:0] tgt
);

  logic cmd_wr, chip_rst_wr, sel_wr;
  assign cmd_wr      = bus_wr && (idx == IX_CMD);
  assign chip_rst_wr = cmd_wr && (opcode == OP_CHIPRST);
  assign sel_wr      = cmd_wr && ((opcode == OP_SEL) || (opcode == OP_SELSTOP));

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    xfer_req && !xfer_done && !chip_rst_wr |=> xfer_req)
    else $error("request dropped early"); // R7

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    xfer_req && xfer_done && !chip_rst_wr |=> irq && !xfer_req)
    else $error("completion did not interrupt"); // R7

  AST_BADTGT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !xfer_req && sel_wr && ({1'b0, tgt} >= (TGT_W + 1)'(TGT_LIMIT)) |=> !xfer_req && irq)
    else $error("bad target started a transfer"); // R8

  AST_CAUSE_READ_ACK: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (idx == IX_INTR) && !(xfer_req && xfer_done) |=> !irq)
    else $error("cause read kept irq"); // R10

  AST_BUSRST_MASKED: assert property (@(posedge clk) disable iff (rst)
    !xfer_req && !irq && cmd_wr && (opcode == OP_BUSRST) && cfg_mask |=> !irq)
    else $error("masked bus reset interrupted"); // R6

  AST_CHIPRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    chip_rst_wr |=> !irq && !xfer_req)
    else $error("chip reset left activity"); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= FCW'(FIFO_DEPTH))
    else $error("fifo count out of range"); // R12

endmodule

bind stor_cmd_regif stor_cmd_regif_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .TGT_W      (TGT_W),
  .TGT_LIMIT  (TGT_LIMIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .idx       (idx),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .opcode    (bus_wdata[6:0]),
  .irq       (irq),
  .xfer_req  (xfer_req),
  .xfer_done (xfer_done),
  .fifo_cnt  (fifo_cnt),
  .cfg_mask  (cfg_q[6]),
  .tgt       (tgt_q)
);

// File: tb/tb_stor_cmd_regif.sv
module tb_stor_cmd_regif;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, xfer_done = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq, xfer_req, dma_mode;
  logic [16:0] xfer_len;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    finished = 0;

  always #2 clk = ~clk;

  stor_cmd_regif dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .xfer_req(xfer_req),
    .xfer_done(xfer_done), .dma_mode(dma_mode), .xfer_len(xfer_len)
  );

  // ---------------- behavioural reference model ----------------
  int       m_cnt, m_cmd, m_status, m_intr, m_seq, m_tgt, m_cfg, m_r11, m_last, m_rdata;
  int       m_hi [4];
  bit       m_irq, m_req, m_job_sel;
  bit [7:0] m_q[$];

  task automatic m_clear();
    m_cnt = 0; m_cmd = 0; m_status = 0; m_intr = 0; m_seq = 0; m_tgt = 0;
    m_cfg = 0; m_r11 = 0; m_last = 0; m_irq = 0; m_req = 0; m_job_sel = 0;
    m_hi[0] = 0; m_hi[1] = 0; m_hi[2] = 4; m_hi[3] = 0;
    m_q.delete();
  endtask

  function automatic int m_read(input int ix);
    case (ix)
      0: return m_cnt & 255;
      1: return (m_cnt >> 8) & 255;
      2: return (m_q.size() > 0) ? int'(m_q[0]) : m_last;
      3: return m_cmd;
      4: return m_status;
      5: return m_intr;
      6: return m_seq;
      7: return m_q.size();
      8: return m_cfg;
      11: return m_r11;
      12, 13, 14, 15: return m_hi[ix - 12];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int ix, op;
    if (rst) begin
      m_clear();
      m_rdata = 0;
    end else begin
      ix = int'(bus_addr[5:2]);
      if (bus_rd) begin
        m_rdata = m_read(ix);
        if (ix == 2 && m_q.size() > 0) m_last = int'(m_q.pop_front());
        if (ix == 5) begin m_status = m_status & 8'h10; m_irq = 0; end
      end
      if (m_req && xfer_done) begin
        if (m_job_sel) begin m_status = 8'h91; m_intr = 8'h18; m_seq = 4; end
        else           begin m_status = 8'h93; m_intr = 8'h10; m_seq = 0; end
        m_irq = 1; m_req = 0;
      end
      if (bus_wr) begin
        case (ix)
          0: m_cnt = (m_cnt & 16'hff00) | int'(bus_wdata);
          1: m_cnt = (m_cnt & 16'h00ff) | (int'(bus_wdata) << 8);
          2: if (m_q.size() < 16) m_q.push_back(bus_wdata);
          3: begin
            op = int'(bus_wdata[6:0]);
            if (op == 2) m_clear();
            else if (!m_req) begin
              m_cmd = int'(bus_wdata);
              case (op)
                1: begin m_intr = 8'h08; m_seq = 0; m_q.delete(); m_last = 0; end
                3: begin m_intr = 8'h80; if (((m_cfg >> 6) & 1) == 0) m_irq = 1; end
                16: begin m_req = 1; m_job_sel = 0; end
                66, 67: begin
                  if (m_tgt >= 4) begin
                    m_status = 8'h80; m_intr = 8'h20; m_seq = 0; m_irq = 1;
                  end else begin
                    m_req = 1; m_job_sel = 1;
                  end
                end
                default: ;
              endcase
            end
          end
          4: m_tgt = int'(bus_wdata[2:0]);
          8: m_cfg = int'(bus_wdata);
          11: m_r11 = int'(bus_wdata) & 8'h15;
          12, 13, 14, 15: m_hi[ix - 12] = int'(bus_wdata);
          default: ;
        endcase
      end
    end
  end

  // ---------------- comparison on every clock ----------------
  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FIFO-free FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("bus_rdata", int'(bus_rdata), m_rdata);
      chk("irq",       int'(irq),       int'(m_irq));
      chk("xfer_req",  int'(xfer_req),  int'(m_req));
      chk("dma_mode",  int'(dma_mode),  (m_cmd >> 7) & 1);
      chk("xfer_len",  int'(xfer_len),  (m_cnt == 0) ? 65536 : m_cnt);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int ix, input int d);
    @(negedge clk);
    bus_addr = 6'(ix << 2); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int ix);
    @(negedge clk);
    bus_addr = 6'(ix << 2); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_all();
    for (int i = 0; i < 16; i++) rd(i);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog %s: actual hung expected finish", cur_req);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values, identification register
    cur_req = "R1"; rd_all();
    // R2: count bytes and zero meaning full length
    cur_req = "R2"; wr(0, 8'h34); wr(1, 8'h12); rd(0); rd(1);
    wr(0, 0); wr(1, 0); idle(1);
    // R3: command readback, dma bit, no-op and undefined opcode
    cur_req = "R3"; wr(3, 8'h80); rd(3); wr(3, 8'h7f); rd(3); rd(4); rd(5); rd(6);
    // R12: fill past full, drain past empty
    cur_req = "R12";
    for (int i = 0; i < 18; i++) wr(2, i * 7 + 1);
    rd(7);
    for (int i = 0; i < 17; i++) rd(2);
    rd(7); rd(2);
    // R4: flush
    cur_req = "R4"; wr(2, 8'haa); wr(2, 8'hbb); rd(2); wr(3, 8'h01); rd(5); rd(6); rd(7); rd(2);
    // R6: bus reset with and without mask
    cur_req = "R6"; wr(3, 8'h03); rd(5);
    wr(8, 8'h40); wr(3, 8'h03); idle(2); rd(5);
    // R7 and R10: good select, completion, acknowledge
    cur_req = "R7"; wr(4, 2); wr(3, 8'hc2); idle(4); done_pulse(); rd(4);
    cur_req = "R10"; rd(5); rd(6); rd(4);
    // R8: bad target
    cur_req = "R8"; wr(4, 5); wr(3, 8'h43); rd(4); rd(6); rd(5);
    // R9 and R13: transfer, ignored commands while busy, stray done
    cur_req = "R9"; wr(3, 8'h10); idle(2);
    cur_req = "R13"; wr(3, 8'h01); wr(3, 8'h03); rd(3); rd(5); rd(6);
    cur_req = "R9"; done_pulse(); rd(4); rd(5);
    cur_req = "R13"; done_pulse(); rd(4); rd(5);
    // R11: register masks and read-only indices
    cur_req = "R11"; wr(11, 8'hff); wr(8, 8'ha5); wr(12, 8'h11); wr(13, 8'h22);
    wr(14, 8'h33); wr(15, 8'h44);
    wr(5, 8'hee); wr(6, 8'hee); wr(7, 8'hee); wr(9, 8'hee); wr(10, 8'hee);
    rd_all();
    // R5: chip reset during pending transfer
    cur_req = "R5"; wr(0, 8'h99); wr(2, 8'h5a); wr(4, 1); wr(3, 8'h42); idle(1);
    wr(3, 8'h02); rd_all(); done_pulse(); rd(4);
    idle(3);
    summary();
  end

endmodule